// File: doc/BRIEF.md
# Synchronous Byte FIFO Link Controller

This block sits on the logic side of a byte-wide synchronous FIFO link to a USB bridge device. All of its inputs and outputs are timed to the clock that the bridge supplies. It watches the bridge's "receive data available" flag and its "transmit space available" flag. It moves receive bytes into a local valid/ready read stream and moves bytes from a local valid/ready write stream out to the bridge. It owns the shared 8-bit data bus. It drives the bus only during write bursts, and it raises the bridge's output-enable a full clock before it issues a read strobe, so that the bus can turn around.

When both directions have work, an arbiter alternates between read and write bursts. Each burst is capped at `MAX_BURST` strobe cycles. A byte offered while the bridge reports no room stays in a holding register and is presented again later. A receive cycle on which the flag has just gone high is dropped. A local flush request produces one low pulse on the bridge's send-immediate line. That pulse never falls inside a write burst.

Top module: `sfifo_link_ctrl`

## Requirements
- R1: While reset is held, all four bridge strobes (`dev_oe_n`, `dev_rd_n`, `dev_wr_n`, `dev_flush_n`) are high, `bus_drive` is low and `rd_valid` is low.
- R2: `bus_drive` is never high in a cycle in which `dev_oe_n` is low.
- R3: `dev_rd_n` falls only after `dev_oe_n` has been low for at least one full preceding cycle.
- R4: One byte is taken from `bus_din` on every rising edge at which `dev_rd_n` and `dev_rx_avail_n` are both low. These bytes come out on the read stream in the same order, with none lost or repeated, even when `rd_ready` stalls.
- R5: `dev_rd_n` is low in a cycle only if `dev_rx_avail_n` was low at the edge that began that cycle. `dev_wr_n` is low only if `dev_tx_space_n` was low at that edge.
- R6: Suppose `dev_rx_avail_n` is high at an edge while `dev_rd_n` is low. No byte is taken at that edge, and in the next cycle `dev_rd_n` and `dev_oe_n` are both high.
- R7: One byte, the current `bus_dout`, goes to the bridge on every edge at which `dev_wr_n` and `dev_tx_space_n` are both low. A byte that does not transfer stays on `bus_dout` until it does. The bridge receives exactly the write-stream bytes, in order.
- R8: `bus_drive` rises only after a cycle in which `dev_oe_n` was high. `dev_oe_n` falls only after a cycle in which `bus_drive` was low.
- R9: No run of `dev_rd_n` low or `dev_wr_n` low lasts more than `MAX_BURST` cycles. When both directions stay pending, both keep making progress.
- R10: Each `flush_req` pulse yields exactly one single-cycle low pulse on `dev_flush_n`. The pulse never falls in a cycle with `dev_wr_n` low. When the link is idle, the pulse comes two cycles after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the bridge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_din | input | 8 | Data bus value as seen from the pads |
| bus_dout | output | 8 | Byte to place on the data bus |
| bus_drive | output | 1 | High when the pad drivers should drive `bus_dout` |
| dev_rx_avail_n | input | 1 | Low when the bridge holds receive data |
| dev_tx_space_n | input | 1 | Low when the bridge can accept transmit data |
| dev_oe_n | output | 1 | Active-low bridge output enable |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dev_flush_n | output | 1 | Active-low send-immediate pulse |
| rd_data | output | 8 | Local read stream data |
| rd_valid | output | 1 | Local read stream valid |
| rd_ready | input | 1 | Local read stream ready |
| wr_data | input | 8 | Local write stream data |
| wr_valid | input | 1 | Local write stream valid |
| wr_ready | output | 1 | Local write stream ready |
| flush_req | input | 1 | Local request for a send-immediate pulse |

## Verification
The bench builds the block with `MAX_BURST` = 4 and a receive queue four entries deep. With these values the burst cap, and the alternation it forces, are reached within a few cycles of continuous traffic. A randomly stalling `rd_ready` also fills the small queue often enough that the room check ends read bursts early. The bridge flags toggle at random, so stalled writes and dropped read cycles occur many times over, alongside directed runs for the exact output-enable lead and the flush timing.

// File: rtl/sfb_pkg.sv
// Shared types for the synchronous FIFO link controller.
// Assumes: one clock domain, the bridge clock.
package sfb_pkg;

    // Link phases: idle, output-enable lead-in, read streaming, write streaming.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_PREP = 2'd1,
        ST_RD_XFER = 2'd2,
        ST_WR_XFER = 2'd3
    } link_state_t;

endpackage

// File: rtl/sfb_rx_queue.sv
// Small receive queue between the bridge read strobe and the local read stream.
// What it does: stores bytes taken from the bus and presents them as a valid/ready stream.
// Assumes: the sequencer never pushes while the queue is full and nothing pops.
module sfb_rx_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    input  logic          out_ready,
    output logic          pop,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;

    assign out_valid = (level != '0);
    assign out_data  = mem[rp];
    assign pop       = out_valid && out_ready;

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= push_data;
        end
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            level <= level + LW'(push) - LW'(pop);
        end
    end

    // R4
    rxq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (level < LW'(DEPTH)));

endmodule

// File: rtl/sfb_tx_stage.sv
// Transmit holding register feeding the data bus.
// What it does: accepts one byte from the local write stream and keeps it on the bus
// until an edge transfers it to the bridge.
// Assumes: 'taken' is asserted only on an edge where the bridge accepts the byte.
module sfb_tx_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         taken,
    output logic         hold_vld,
    output logic         hold_vld_nxt,
    output logic [W-1:0] hold_data
);

    logic load;

    assign in_ready     = !hold_vld || taken;
    assign load         = in_valid && in_ready;
    assign hold_vld_nxt = load || (hold_vld && !taken);

    // Hold register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_data <= '0;
        end else begin
            hold_vld <= hold_vld_nxt;
            if (load) begin
                hold_data <= in_data;
            end
        end
    end

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !taken) |=> (hold_vld && $stable(hold_data)));

    // R7
    taken_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> hold_vld);

endmodule

// File: rtl/sfb_flush_gen.sv
// Send-immediate pulse generator.
// What it does: records a local flush request and emits one low pulse as soon as
// the next cycle is not a write burst cycle.
// Assumes: 'blocked' reports that the next cycle is a write burst cycle.
module sfb_flush_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic blocked,
    output logic pend,
    output logic pulse_n
);

    logic issue;

    assign issue = pend && !blocked;

    // Pending flag and pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pulse_n <= 1'b1;
        end else begin
            pend    <= (pend && !issue) || req;
            pulse_n <= !issue;
        end
    end

    // R10
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_n |=> pulse_n);

endmodule

// File: rtl/sfb_sequencer.sv
// Handshake sequencer for the bridge link.
// What it does: picks read or write bursts, drives the output enable and the strobes
// from registers, and ends bursts on a flag change, a full queue or the burst cap.
// Assumes: MAX_BURST >= 2. Flags are sampled at the clock edge.
module sfb_sequencer
    import sfb_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int MAX_BURST = 8,
    localparam int LW       = $clog2(DEPTH + 1),
    localparam int BW       = $clog2(MAX_BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_avail_n,
    input  logic          tx_space_n,
    input  logic [LW-1:0] rxq_level,
    input  logic          rxq_pop,
    input  logic          hold_vld,
    input  logic          hold_vld_nxt,
    input  logic          flush_pend,
    output logic          rx_push,
    output logic          tx_taken,
    output logic          wr_grant_nxt,
    output logic          oe_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          drive
);

    link_state_t   st;
    link_state_t   st_nxt;
    logic [BW-1:0] beats;
    logic          last_rd;
    logic [LW:0]   lvl_nxt;
    logic          room;
    logic          cap;
    logic          rd_ok;
    logic          wr_ok;

    assign rx_push      = !rd_n && !rx_avail_n;
    assign tx_taken     = !wr_n && !tx_space_n;
    assign lvl_nxt      = (LW + 1)'(rxq_level) + (LW + 1)'(rx_push) - (LW + 1)'(rxq_pop);
    assign room         = lvl_nxt < (LW + 1)'(DEPTH);
    assign cap          = (beats == BW'(MAX_BURST - 1));
    assign rd_ok        = !rx_avail_n && room;
    assign wr_ok        = hold_vld && !tx_space_n && !flush_pend;
    assign wr_grant_nxt = (st_nxt == ST_WR_XFER);

    // Next-phase selection with alternating grant.
    always_comb begin
        st_nxt = st;
        case (st)
            ST_IDLE: begin
                if (rd_ok && (!wr_ok || !last_rd)) begin
                    st_nxt = ST_RD_PREP;
                end else if (wr_ok) begin
                    st_nxt = ST_WR_XFER;
                end
            end
            ST_RD_PREP: st_nxt = rd_ok ? ST_RD_XFER : ST_IDLE;
            ST_RD_XFER: st_nxt = (rd_ok && !cap) ? ST_RD_XFER : ST_IDLE;
            ST_WR_XFER: st_nxt = (!tx_space_n && hold_vld_nxt && !cap) ? ST_WR_XFER : ST_IDLE;
            default:    st_nxt = ST_IDLE;
        endcase
    end

    // Phase, burst counter and grant history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            beats   <= '0;
            last_rd <= 1'b0;
        end else begin
            st <= st_nxt;
            if ((st_nxt == st) && (st == ST_RD_XFER || st == ST_WR_XFER)) begin
                beats <= beats + 1'b1;
            end else begin
                beats <= '0;
            end
            if (st == ST_IDLE && st_nxt == ST_RD_PREP) begin
                last_rd <= 1'b1;
            end else if (st == ST_IDLE && st_nxt == ST_WR_XFER) begin
                last_rd <= 1'b0;
            end
        end
    end

    // Registered bridge-side strobes and bus direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_n  <= 1'b1;
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
            drive <= 1'b0;
        end else begin
            oe_n  <= !(st_nxt == ST_RD_PREP || st_nxt == ST_RD_XFER);
            rd_n  <= !(st_nxt == ST_RD_XFER);
            wr_n  <= !(st_nxt == ST_WR_XFER);
            drive <= (st_nxt == ST_WR_XFER);
        end
    end

    // R3
    oe_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(oe_n));

    // R5
    rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !$past(rx_avail_n));

    // R5
    wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !$past(tx_space_n));

    // R6
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && rx_avail_n) |=> (rd_n && oe_n));

    // R8
    drive_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(oe_n));

    // R8
    oe_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(drive));

    // R9
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (beats < BW'(MAX_BURST)));

endmodule

// File: rtl/sfifo_link_ctrl.sv
// Top of the synchronous FIFO link controller.
// What it does: joins the sequencer, the receive queue, the transmit holding stage
// and the flush pulse generator into one bridge-side interface.
// Assumes: the pad drivers put bus_dout on the bus while bus_drive is high and
// present the bus value on bus_din.
module sfifo_link_ctrl #(
    parameter int DATA_W    = 8,
    parameter int RXQ_DEPTH = 4,
    parameter int MAX_BURST = 8,
    localparam int LW       = $clog2(RXQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_drive,
    input  logic              dev_rx_avail_n,
    input  logic              dev_tx_space_n,
    output logic              dev_oe_n,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic              dev_flush_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic              flush_req
);

    logic          rx_push;
    logic          rxq_pop;
    logic [LW-1:0] rxq_level;
    logic          tx_taken;
    logic          hold_vld;
    logic          hold_vld_nxt;
    logic          flush_pend;
    logic          wr_grant_nxt;

    sfb_sequencer #(
        .DEPTH     (RXQ_DEPTH),
        .MAX_BURST (MAX_BURST)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_avail_n   (dev_rx_avail_n),
        .tx_space_n   (dev_tx_space_n),
        .rxq_level    (rxq_level),
        .rxq_pop      (rxq_pop),
        .hold_vld     (hold_vld),
        .hold_vld_nxt (hold_vld_nxt),
        .flush_pend   (flush_pend),
        .rx_push      (rx_push),
        .tx_taken     (tx_taken),
        .wr_grant_nxt (wr_grant_nxt),
        .oe_n         (dev_oe_n),
        .rd_n         (dev_rd_n),
        .wr_n         (dev_wr_n),
        .drive        (bus_drive)
    );

    sfb_rx_queue #(
        .W     (DATA_W),
        .DEPTH (RXQ_DEPTH)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (bus_din),
        .out_valid (rd_valid),
        .out_data  (rd_data),
        .out_ready (rd_ready),
        .pop       (rxq_pop),
        .level     (rxq_level)
    );

    sfb_tx_stage #(
        .W (DATA_W)
    ) u_txs (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (wr_valid),
        .in_data      (wr_data),
        .in_ready     (wr_ready),
        .taken        (tx_taken),
        .hold_vld     (hold_vld),
        .hold_vld_nxt (hold_vld_nxt),
        .hold_data    (bus_dout)
    );

    sfb_flush_gen u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (flush_req),
        .blocked (wr_grant_nxt),
        .pend    (flush_pend),
        .pulse_n (dev_flush_n)
    );

    // R2
    oe_drive_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> !bus_drive);

    // R10
    flush_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_flush_n |-> dev_wr_n);

endmodule

// File: tb/sfifo_link_ctrl_bench.sv
// Self-checking bench: a bridge model with random flags plus random local streams,
// together with directed runs for output-enable lead, dropped reads, flush and starvation.
module sfifo_link_ctrl_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MAXB  = 4;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_drive;
    logic       dev_rx_avail_n = 1'b1;
    logic       dev_tx_space_n = 1'b1;
    logic       dev_oe_n, dev_rd_n, dev_wr_n, dev_flush_n;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       rd_ready = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic       flush_req = 1'b0;

    always #2.5 clk = ~clk;

    sfifo_link_ctrl #(
        .DATA_W    (8),
        .RXQ_DEPTH (DEPTH),
        .MAX_BURST (MAXB)
    ) u_sfifo_link_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_din        (bus_din),
        .bus_dout       (bus_dout),
        .bus_drive      (bus_drive),
        .dev_rx_avail_n (dev_rx_avail_n),
        .dev_tx_space_n (dev_tx_space_n),
        .dev_oe_n       (dev_oe_n),
        .dev_rd_n       (dev_rd_n),
        .dev_wr_n       (dev_wr_n),
        .dev_flush_n    (dev_flush_n),
        .rd_data        (rd_data),
        .rd_valid       (rd_valid),
        .rd_ready       (rd_ready),
        .wr_data        (wr_data),
        .wr_valid       (wr_valid),
        .wr_ready       (wr_ready),
        .flush_req      (flush_req)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // knobs (percent) and stream bookkeeping
    int p_rx = 0, p_tx = 0, p_wv = 0, p_rr = 0;
    int rx_total = 0, tx_total = 0;
    int rx_i = 0, rd_i = 0, tx_src_i = 0, tx_chk_i = 0;
    int flush_reqs = 0, flush_pulses = 0;
    bit flush_next = 1'b0;
    logic rst_next = 1'b0;
    int rd_run = 0, wr_run = 0;
    logic prev_oe_n = 1'b1, prev_rd_n = 1'b1, prev_flush_n = 1'b1;
    logic prev_drive = 1'b0, prev_rx = 1'b1, prev_tx = 1'b1;

    function automatic logic [7:0] rx_byte(int i);
        return 8'((i * 37 + 11) ^ (i >> 2));
    endfunction

    function automatic logic [7:0] tx_byte(int i);
        return 8'((i * 91 + 5) ^ 8'h5A ^ (i >> 3));
    endfunction

    function automatic bit roll(int pct);
        return int'($urandom_range(99)) < pct;
    endfunction

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, sample just before the rising edge.
    task automatic step();
        @(negedge clk);
        rst_n          = rst_next;
        dev_rx_avail_n = !((rx_i < rx_total) && roll(p_rx));
        dev_tx_space_n = !roll(p_tx);
        bus_din        = dev_oe_n ? 8'h00 : rx_byte(rx_i);
        wr_valid       = (tx_src_i < tx_total) && roll(p_wv);
        wr_data        = tx_byte(tx_src_i);
        rd_ready       = roll(p_rr);
        flush_req      = flush_next;
        flush_next     = 1'b0;
        #2;
        if (rst_n) begin
            // R2
            if (bus_drive) chk("R2", dev_oe_n == 1'b1, dev_oe_n, 1);
            // R3
            if (!dev_rd_n && prev_rd_n) chk("R3", prev_oe_n == 1'b0, prev_oe_n, 0);
            // R5
            if (!dev_rd_n) chk("R5 read flag", prev_rx == 1'b0, prev_rx, 0);
            if (!dev_wr_n) chk("R5 write flag", prev_tx == 1'b0, prev_tx, 0);
            // R6
            if (!prev_rd_n && prev_rx) chk("R6", dev_rd_n && dev_oe_n, {dev_rd_n, dev_oe_n}, 3);
            // R8
            if (bus_drive && !prev_drive) chk("R8 drive", prev_oe_n == 1'b1, prev_oe_n, 1);
            if (!dev_oe_n && prev_oe_n) chk("R8 oe", prev_drive == 1'b0, prev_drive, 0);
            // R9
            rd_run = dev_rd_n ? 0 : rd_run + 1;
            wr_run = dev_wr_n ? 0 : wr_run + 1;
            if (!dev_rd_n) chk("R9 read burst", rd_run <= MAXB, rd_run, MAXB);
            if (!dev_wr_n) chk("R9 write burst", wr_run <= MAXB, wr_run, MAXB);
            // R10
            if (!dev_flush_n) begin
                flush_pulses++;
                chk("R10 not in write", dev_wr_n == 1'b1, dev_wr_n, 1);
                chk("R10 single", prev_flush_n == 1'b1, prev_flush_n, 1);
            end
            // R7: bridge sink
            if (!dev_wr_n && !dev_tx_space_n) begin
                chk("R7 drive", bus_drive == 1'b1, bus_drive, 1);
                chk("R7 byte", bus_dout == tx_byte(tx_chk_i), bus_dout, tx_byte(tx_chk_i));
                tx_chk_i++;
            end
            // R4: bridge source advance and local read stream
            if (!dev_rd_n && !dev_rx_avail_n) rx_i++;
            if (rd_valid && rd_ready) begin
                chk("R4 byte", rd_data == rx_byte(rd_i), rd_data, rx_byte(rd_i));
                rd_i++;
            end
            if (wr_valid && wr_ready) tx_src_i++;
        end
        prev_oe_n    = dev_oe_n;
        prev_rd_n    = dev_rd_n;
        prev_flush_n = dev_flush_n;
        prev_drive   = bus_drive;
        prev_rx      = dev_rx_avail_n;
        prev_tx      = dev_tx_space_n;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int r0, t0;
        void'($urandom(32'd90210));

        // R1: reset state
        rst_next = 1'b0;
        for (int k = 0; k < 3; k++) step();
        chk("R1 oe", dev_oe_n == 1'b1, dev_oe_n, 1);
        chk("R1 rd", dev_rd_n == 1'b1, dev_rd_n, 1);
        chk("R1 wr", dev_wr_n == 1'b1, dev_wr_n, 1);
        chk("R1 flush", dev_flush_n == 1'b1, dev_flush_n, 1);
        chk("R1 drive", bus_drive == 1'b0, bus_drive, 0);
        chk("R1 rd_valid", rd_valid == 1'b0, rd_valid, 0);
        rst_next = 1'b1;
        for (int k = 0; k < 3; k++) step();

        // R3/R6 directed: three bytes, exact output-enable lead, then flag rises mid-burst
        rx_total = rx_i + 3; p_rx = 100; p_rr = 100; p_wv = 0; p_tx = 0;
        step();
        chk("R3 cycle0", dev_oe_n && dev_rd_n, {dev_oe_n, dev_rd_n}, 3);
        step();
        chk("R3 lead oe", dev_oe_n == 1'b0, dev_oe_n, 0);
        chk("R3 lead rd", dev_rd_n == 1'b1, dev_rd_n, 1);
        step();
        chk("R3 strobe", dev_rd_n == 1'b0, dev_rd_n, 0);
        for (int k = 0; k < 3; k++) step();
        chk("R6 flag high", dev_rd_n == 1'b0 && dev_rx_avail_n == 1'b1,
            {dev_rd_n, dev_rx_avail_n}, 1);
        step();
        chk("R6 release", dev_rd_n && dev_oe_n, {dev_rd_n, dev_oe_n}, 3);
        for (int k = 0; k < 4; k++) step();
        chk("R4 directed count", rd_i == rx_total, rd_i, rx_total);

        // R10 directed: idle latency of two cycles
        flush_next = 1'b1; flush_reqs++;
        step();
        chk("R10 c0", dev_flush_n == 1'b1, dev_flush_n, 1);
        step();
        chk("R10 c1", dev_flush_n == 1'b1, dev_flush_n, 1);
        step();
        chk("R10 c2", dev_flush_n == 1'b0, dev_flush_n, 0);
        step();
        chk("R10 c3", dev_flush_n == 1'b1, dev_flush_n, 1);

        // R10 directed: flush requested during continuous writes
        tx_total = tx_src_i + 40; p_wv = 100; p_tx = 100;
        for (int k = 0; k < 3; k++) step();
        flush_next = 1'b1; flush_reqs++;
        for (int k = 0; k < 20; k++) step();
        chk("R10 during writes", flush_pulses == flush_reqs, flush_pulses, flush_reqs);

        // R9 directed: both directions saturated
        rx_total = 1 << 30; tx_total = 1 << 30;
        p_rx = 100; p_tx = 100; p_wv = 100; p_rr = 100;
        r0 = rd_i; t0 = tx_chk_i;
        for (int k = 0; k < 220; k++) step();
        chk("R9 read progress", (rd_i - r0) >= 60, rd_i - r0, 60);
        chk("R9 write progress", (tx_chk_i - t0) >= 60, tx_chk_i - t0, 60);

        // Random phase
        for (int blk = 0; blk < 20; blk++) begin
            p_rx = int'($urandom_range(100));
            p_tx = int'($urandom_range(100));
            p_wv = int'($urandom_range(100));
            p_rr = int'($urandom_range(100));
            for (int k = 0; k < 200; k++) begin
                if (flush_reqs == flush_pulses && roll(2)) begin
                    flush_next = 1'b1;
                    flush_reqs++;
                end
                step();
            end
        end

        // Drain and final accounting
        p_rx = 0; p_wv = 0; p_tx = 100; p_rr = 100;
        for (int k = 0; k < 60; k++) step();
        chk("R4 all delivered", rd_i == rx_i, rd_i, rx_i);
        chk("R7 all delivered", tx_chk_i == tx_src_i, tx_chk_i, tx_src_i);
        chk("R10 pulse count", flush_pulses == flush_reqs, flush_pulses, flush_reqs);
        finish_run();
    end

endmodule